// File: doc/BRIEF.md
# Relative Branch and Loop Resolver

This unit settles short and near relative control transfers for a core with a 16-bit instruction pointer. Each request carries an operation code, the current instruction pointer, the instruction length, a displacement that has already been sign-extended to 16 bits, five status flags and the 16-bit count register. One clock later the unit reports whether the transfer is taken and the next instruction pointer. For the three counted-loop operations it also returns the decremented count with a write strobe. Loop operations never produce or alter flags. Their branch test looks at the count after the decrement. The zero-flag variants combine that test with the incoming zero flag.

The target is always measured from the instruction that follows the branch: the instruction pointer plus the length, plus the displacement. All of this wraps modulo 2^16. A transfer that is not taken continues at the instruction pointer plus the length.

Top module: `branch_resolver`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, res_valid, taken, cnt_we, next_ip and cnt_out are all 0.
- R2: A request sampled with req_valid high produces its result at the next rising edge, with res_valid high for that one cycle. When req_valid is low, res_valid and cnt_we are 0, and taken, next_ip and cnt_out keep their previous values whatever the other inputs do.
- R3: A taken transfer sets next_ip = (ip + ilen + disp) mod 2^16, where disp is the 16-bit two's-complement displacement. A short jump at 0x100D with length 2 and displacement 0x0006 goes to 0x1015. One at 0x1019 with displacement 0xFFEC goes to 0x1007.
- R4: A transfer that is not taken sets next_ip = (ip + ilen) mod 2^16.
- R5: Flag jumps use these op codes: 0 taken if carry=1, 1 if carry=0, 2 if parity=1, 3 if parity=0, 4 if overflow=1, 5 if overflow=0, 6 if sign=1, 7 if sign=0, 8 if zero=1, 9 if zero=0. For these, cnt_we=0 and cnt_out = cnt_in.
- R6: Op 10 (counted loop) sets cnt_out = cnt_in - 1 with cnt_we=1. It is taken exactly when that new count is nonzero.
- R7: Op 11 (loop while equal) decrements like R6 and is taken only when the new count is nonzero and zero=1.
- R8: Op 12 (loop while not equal) decrements like R6 and is taken only when the new count is nonzero and zero=0.
- R9: Op 13 (jump on count zero) is taken exactly when cnt_in is 0. It leaves the count alone: cnt_we=0 and cnt_out = cnt_in.
- R10: Ops 14 and 15 are never taken. They give cnt_we=0 and cnt_out = cnt_in.
- R11: The loop decrement wraps: cnt_in = 0 gives cnt_out = 0xFFFF, which counts as nonzero for the branch test. cnt_in = 1 gives 0 and falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code (R5 to R10) |
| ip | input | 16 | Address of the branch instruction |
| ilen | input | 4 | Length of the branch instruction in bytes |
| disp | input | 16 | Sign-extended displacement |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag |
| flag_o | input | 1 | Overflow flag |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| cnt_in | input | 16 | Current count register |
| res_valid | output | 1 | Result present |
| taken | output | 1 | Transfer taken |
| next_ip | output | 16 | Next instruction pointer |
| cnt_out | output | 16 | Count value to write back |
| cnt_we | output | 1 | Count write strobe |

## Verification
The count decrement and the branch decision fall in the same cycle, and the decision must use the decremented count rather than the incoming one. This is provoked with loop requests at cnt_in values of 1, 0 and 2, both with the zero flag set and with it clear. The target sum can also carry past 0xFFFF in the same cycle, so near-wrap instruction pointers are mixed in as well. Every result is judged against a bench model of the decision and the address, comparing taken, next_ip, cnt_out and cnt_we together.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int IPW = 16,
  parameter int CW  = 16,
  parameter int LW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [3:0]     op,
  input  logic [IPW-1:0] ip,
  input  logic [LW-1:0]  ilen,
  input  logic [IPW-1:0] disp,
  input  logic           flag_c,
  input  logic           flag_p,
  input  logic           flag_o,
  input  logic           flag_s,
  input  logic           flag_z,
  input  logic [CW-1:0]  cnt_in,
  output logic           res_valid,
  output logic           taken,
  output logic [IPW-1:0] next_ip,
  output logic [CW-1:0]  cnt_out,
  output logic           cnt_we
);
  localparam logic [3:0] OP_LOOP   = 4'd10;
  localparam logic [3:0] OP_LOOPZ  = 4'd11;
  localparam logic [3:0] OP_LOOPNZ = 4'd12;
  localparam logic [3:0] OP_CXZ    = 4'd13;

  logic [CW-1:0]  cnt_dec;
  logic           dec_nz, is_loop, go;
  logic [IPW-1:0] fall_ip, tgt_ip;

  assign cnt_dec = cnt_in - 1'b1;
  assign dec_nz  = |cnt_dec;
  assign is_loop = (op == OP_LOOP) || (op == OP_LOOPZ) || (op == OP_LOOPNZ);
  assign fall_ip = ip + IPW'(ilen);
  assign tgt_ip  = fall_ip + disp;

  always_comb begin
    case (op)
      4'd0:      go = flag_c;
      4'd1:      go = !flag_c;
      4'd2:      go = flag_p;
      4'd3:      go = !flag_p;
      4'd4:      go = flag_o;
      4'd5:      go = !flag_o;
      4'd6:      go = flag_s;
      4'd7:      go = !flag_s;
      4'd8:      go = flag_z;
      4'd9:      go = !flag_z;
      OP_LOOP:   go = dec_nz;
      OP_LOOPZ:  go = dec_nz && flag_z;
      OP_LOOPNZ: go = dec_nz && !flag_z;
      OP_CXZ:    go = (cnt_in == '0);
      default:   go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      next_ip   <= '0;
      cnt_out   <= '0;
      cnt_we    <= 1'b0;
    end else begin
      res_valid <= req_valid;
      cnt_we    <= req_valid && is_loop;
      if (req_valid) begin
        taken   <= go;
        next_ip <= go ? tgt_ip : fall_ip;
        cnt_out <= is_loop ? cnt_dec : cnt_in;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) |-> res_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !cnt_we && $stable(next_ip) && $stable(taken) && $stable(cnt_out));
  p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken) |-> next_ip == IPW'($past(ip) + IPW'($past(ilen)) + $past(disp)));
  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> next_ip == IPW'($past(ip) + IPW'($past(ilen))));
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> cnt_out == CW'($past(cnt_in) - 1'b1));
  p_zero_falls_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && cnt_out == '0) |-> !taken);
  p_cxz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op) == OP_CXZ) |-> !cnt_we && taken == ($past(cnt_in) == '0));
endmodule

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] op = '0, ilen = '0;
  logic [15:0] ip = '0, disp = '0, cnt_in = '0;
  logic flag_c = 0, flag_p = 0, flag_o = 0, flag_s = 0, flag_z = 0;
  logic res_valid, taken, cnt_we;
  logic [15:0] next_ip, cnt_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_resolver u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .ip(ip),
    .ilen(ilen), .disp(disp), .flag_c(flag_c), .flag_p(flag_p), .flag_o(flag_o),
    .flag_s(flag_s), .flag_z(flag_z), .cnt_in(cnt_in), .res_valid(res_valid),
    .taken(taken), .next_ip(next_ip), .cnt_out(cnt_out), .cnt_we(cnt_we));

  function automatic string tag_of(input logic [3:0] o, input logic [15:0] c);
    if (o <= 4'd9) return "R5";
    if (o == 4'd10) return (c == 16'd0 || c == 16'd1) ? "R11" : "R6";
    if (o == 4'd11) return "R7";
    if (o == 4'd12) return "R8";
    if (o == 4'd13) return "R9";
    return "R10";
  endfunction

  function automatic logic ref_go(input logic [3:0] o, input logic c, p, v, s, z,
                                  input logic [15:0] cnt);
    logic [15:0] n;
    n = cnt - 16'd1;
    case (o)
      0: return c;   1: return !c;  2: return p;  3: return !p;
      4: return v;   5: return !v;  6: return s;  7: return !s;
      8: return z;   9: return !z;
      10: return n != 0;
      11: return (n != 0) && z;
      12: return (n != 0) && !z;
      13: return cnt == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [15:0] a, input logic [3:0] l,
                       input logic [15:0] d, input logic [4:0] f, input logic [15:0] cnt);
    logic eg, ew;
    logic [15:0] eip, ecnt;
    op = o; ip = a; ilen = l; disp = d; cnt_in = cnt;
    {flag_o, flag_s, flag_z, flag_p, flag_c} = f;
    req_valid = 1'b1;
    eg = ref_go(o, f[0], f[1], f[4], f[3], f[2], cnt);
    ew = (o >= 4'd10 && o <= 4'd12);
    eip = eg ? 16'(a + 16'(l) + d) : 16'(a + 16'(l));
    ecnt = ew ? 16'(cnt - 16'd1) : cnt;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (res_valid !== 1'b1 || taken !== eg || next_ip !== eip || cnt_out !== ecnt || cnt_we !== ew) begin
      fails++;
      $display("FAIL %s R3/R4 op=%0d: got v=%b t=%b ip=%h cnt=%h we=%b exp v=1 t=%b ip=%h cnt=%h we=%b",
               tag_of(o, cnt), o, res_valid, taken, next_ip, cnt_out, cnt_we, eg, eip, ecnt, ew);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic t0;
    logic [15:0] ip0, c0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid || taken || cnt_we || next_ip != 0 || cnt_out != 0) begin
      fails++;
      $display("FAIL R1 reset: v=%b t=%b we=%b ip=%h cnt=%h exp all 0", res_valid, taken, cnt_we, next_ip, cnt_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid || taken || cnt_we || next_ip != 0 || cnt_out != 0) begin
      fails++;
      $display("FAIL R1 after reset: v=%b t=%b ip=%h exp 0", res_valid, taken, next_ip);
    end
    // R3 directed short jumps (carry set, op 0)
    apply(4'd0, 16'h100D, 4'd2, 16'h0006, 5'b00001, 16'h0000);
    apply(4'd0, 16'h1019, 4'd2, 16'hFFEC, 5'b00001, 16'h0000);
    // R3 near displacement and wrap past 0xFFFF
    apply(4'd9, 16'hFFF0, 4'd3, 16'h0100, 5'b00000, 16'h0005);
    apply(4'd1, 16'h0002, 4'd2, 16'hFF00, 5'b00000, 16'h0005);
    // R4 not taken near wrap
    apply(4'd8, 16'hFFFF, 4'd2, 16'h0040, 5'b00000, 16'h0005);
    // R6/R7/R8/R11 decrement and decision in the same cycle
    apply(4'd10, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0001);
    apply(4'd10, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0000);
    apply(4'd10, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0002);
    apply(4'd11, 16'h2000, 4'd2, 16'hFFF0, 5'b00100, 16'h0002);
    apply(4'd11, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0002);
    apply(4'd11, 16'h2000, 4'd2, 16'hFFF0, 5'b00100, 16'h0001);
    apply(4'd12, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0002);
    apply(4'd12, 16'h2000, 4'd2, 16'hFFF0, 5'b00100, 16'h0002);
    apply(4'd12, 16'h2000, 4'd2, 16'hFFF0, 5'b00000, 16'h0000);
    // R9 count zero jump
    apply(4'd13, 16'h3000, 4'd2, 16'h0010, 5'b00000, 16'h0000);
    apply(4'd13, 16'h3000, 4'd2, 16'h0010, 5'b11111, 16'h0001);
    // R10 unused codes
    apply(4'd14, 16'h4000, 4'd2, 16'h0010, 5'b11111, 16'h0007);
    apply(4'd15, 16'h4000, 4'd2, 16'h0010, 5'b11111, 16'h0000);
    // R2 hold: inputs change without req_valid
    t0 = taken; ip0 = next_ip; c0 = cnt_out;
    op = 4'd10; ip = 16'h5555; cnt_in = 16'h0009; flag_z = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid || cnt_we || taken !== t0 || next_ip !== ip0 || cnt_out !== c0) begin
      fails++;
      $display("FAIL R2 hold: v=%b we=%b t=%b ip=%h cnt=%h exp v=0 we=0 t=%b ip=%h cnt=%h",
               res_valid, cnt_we, taken, next_ip, cnt_out, t0, ip0, c0);
    end
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [15:0] rc;
      rc = ($urandom % 4 == 0) ? 16'($urandom % 3) : 16'($urandom);
      apply(4'($urandom), 16'($urandom), 4'($urandom % 15 + 1), 16'($urandom), 5'($urandom), rc);
      if (i % 7 == 0) @(negedge clk);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule